// File: doc/BRIEF.md
# Return-Driven Microprogram Sequencer

This block runs a small stored program. Each program state holds two entries. The sequencer picks one of them from the one-bit answer to the action it issued in the previous step: zero (Z) or nonzero (NZ). An entry gives the next state and a mask of action strobes. Some bits of the mask drive units inside the block: a no-operation unit and a set of unary counters that support increment and test-and-decrement. The remaining bits leave the block as one-cycle strobes to external units. Those units answer on a shared return interface.

After issuing an entry's strobes, the sequencer collects answers over a wait period of `CYCLE_LEN` clocks. If exactly one answer has arrived when the period ends, it records that answer and fetches the next entry. If no answer has arrived, it waits for further periods until one does. An entry whose mask holds no answer-producing action halts the sequencer. Two or more answers in one period put it into a sticky fault state, and so does reaching an entry that was never made valid.

The program is written through a port that only accepts writes while `run_en` is low. Raising `run_en` starts a run from state `INIT_STATE` with the previous answer taken as Z. Dropping `run_en` returns the block to idle.

The controller states are:
- IDLE: not running; program writes are accepted.
- FETCH: reads and judges the selected entry.
- WAIT: collects answers.
- HALT: terminal state after an entry with no answer-producing action.
- FAULT: terminal error state.

The transitions are:
- IDLE→FETCH when `run_en` rises.
- FETCH→WAIT when the entry is valid and holds an answer-producing action.
- FETCH→HALT when the entry is valid and holds no answer-producing action.
- FETCH→FAULT when the entry is invalid.
- WAIT→WAIT at the end of a period with no answer.
- WAIT→FETCH at the end of a period with exactly one answer.
- WAIT→FAULT at the end of a period with two or more answers.
- any state→IDLE when `run_en` is low.

Top module: `retsel_sequencer`

## Requirements
- R1: After reset, or one clock after `run_en` is sampled low, `running`, `halted` and `error` are 0. After reset, all strobes, counters and overflow flags are also 0 and no program entry is valid.
- R2: A run starts at `INIT_STATE` with the previous answer taken as Z. Each step uses the entry indexed by {current state, previous answer}, and `last_nz` and `cur_state` report the step taken.
- R3: The `prog_sel` input selects what a write does:
  - 0 writes only the Z slot.
  - 1 writes only the NZ slot.
  - 2 writes both slots.
  - 3 writes the Z slot and marks the NZ slot invalid.
  Fetching an invalid entry raises `error` with `cur_state` holding that state.
- R4: Program writes while `run_en` is high have no effect.
- R5: The mask layout is bit 0 for NOP, then `NUM_CTR` increment bits, then `NUM_CTR` test-and-decrement bits, then `EXT_ACT` external bits. An entry whose mask has no answer-producing bit still issues its actions. It then sets `halted`, which stays set while `run_en` is high, and `cur_state` holds that state.
- R6: Two or more answers within one wait period set `error`, and the sequencer stops.
- R7: Each external strobe of an entry is high for exactly one clock. If no answer arrives within a period, the sequencer keeps waiting without re-issuing strobes, and `running` stays 1.
- R8: The NOP action answers Z and changes nothing else.
- R9: Increment adds one to a counter and gives no answer. Test-and-decrement on a nonzero counter answers NZ and subtracts one. On a zero counter it answers Z and leaves the counter at 0.
- R10: Incrementing a counter at its maximum value leaves it at the maximum and sets that counter's sticky overflow flag.
- R11: Increment and test-and-decrement of the same counter in one entry: the test uses the old value. The net change is +1 when the old value was 0 and none otherwise.
- R12: An external answer (`ret_valid` with `ret_nz`) chooses between the Z and NZ entries of the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High to run, low to stop and allow program writes |
| prog_we | input | 1 | Program write strobe |
| prog_state | input | STATE_W | State index being written |
| prog_sel | input | 2 | Slot selection code (see R3) |
| prog_next | input | STATE_W | Next state stored in the entry |
| prog_mask | input | ACT_W | Action mask stored in the entry |
| act_strobe | output | EXT_ACT | One-cycle strobes to external units |
| ret_valid | input | 1 | External answer present |
| ret_nz | input | 1 | External answer value, 1 for NZ |
| running | output | 1 | In FETCH or WAIT |
| halted | output | 1 | In HALT |
| error | output | 1 | In FAULT |
| cur_state | output | STATE_W | Current program state |
| last_nz | output | 1 | Previous answer, 1 for NZ |
| ctr_value | output | NUM_CTR*CTR_W | Counter values, counter 0 in the low bits |
| ctr_ovf | output | NUM_CTR | Sticky overflow flags |

## Verification
Two pairs of functions can meet in the same cycle.

The first pair is an increment and a test-and-decrement of one counter fired by a single entry. The bench provokes it at counter values 0 and 1. It judges the result by the final counter value, the recorded answer and the state the run halts in.

The second pair is an internal answer and an external answer landing in the same wait period. The bench provokes it with an entry that fires NOP alongside an answering external strobe and returns an answer right after the strobe. It expects `error` rather than a step. A random run also sets a late external answer against program writes made during the wait, to confirm that those writes change nothing.

// File: rtl/retsel_pkg.sv
package retsel_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_WAIT,
        SQ_HALT,
        SQ_FAULT
    } seq_state_t;

    typedef enum logic [1:0] {
        WSEL_Z     = 2'd0,
        WSEL_NZ    = 2'd1,
        WSEL_BOTH  = 2'd2,
        WSEL_ZONLY = 2'd3
    } wsel_t;

endpackage

// File: rtl/retsel_progmem.sv
module retsel_progmem
    import retsel_pkg::*;
#(
    parameter int STATE_W = 4,
    parameter int ACT_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [STATE_W-1:0] wstate,
    input  logic [1:0]         wsel,
    input  logic [STATE_W-1:0] wnext,
    input  logic [ACT_W-1:0]   wmask,
    input  logic [STATE_W-1:0] rstate,
    input  logic               rlast,
    output logic               ent_vld,
    output logic [STATE_W-1:0] ent_next,
    output logic [ACT_W-1:0]   ent_mask
);
    localparam int SLOTS = 2 << STATE_W;

    logic [STATE_W-1:0] next_mem [SLOTS];
    logic [ACT_W-1:0]   mask_mem [SLOTS];
    logic [SLOTS-1:0]   vld_q;
    logic [1:0]         slot_wr;
    logic               nz_kill;

    // Slot 0 is the Z slot, slot 1 the NZ slot.
    always_comb begin
        slot_wr = 2'b00;
        nz_kill = 1'b0;
        if (we) begin
            unique case (wsel_t'(wsel))
                WSEL_Z:     slot_wr = 2'b01;
                WSEL_NZ:    slot_wr = 2'b10;
                WSEL_BOTH:  slot_wr = 2'b11;
                WSEL_ZONLY: begin
                    slot_wr = 2'b01;
                    nz_kill = 1'b1;
                end
                default:    slot_wr = 2'b00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < 2; s++) begin
            if (slot_wr[s]) begin
                next_mem[{wstate, s[0]}] <= wnext;
                mask_mem[{wstate, s[0]}] <= wmask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int s = 0; s < 2; s++) begin
                if (slot_wr[s]) vld_q[{wstate, s[0]}] <= 1'b1;
            end
            if (nz_kill) vld_q[{wstate, 1'b1}] <= 1'b0;
        end
    end

    assign ent_vld  = vld_q[{rstate, rlast}];
    assign ent_next = next_mem[{rstate, rlast}];
    assign ent_mask = mask_mem[{rstate, rlast}];

endmodule

// File: rtl/retsel_ctr.sv
module retsel_ctr #(
    parameter int CTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             tdec,
    output logic [CTR_W-1:0] value,
    output logic             ovf,
    output logic             rsp_vld,
    output logic             rsp_nz
);
    localparam logic [CTR_W-1:0] MAXV = '1;

    logic nonzero;
    logic take;

    assign nonzero = (value != '0);
    assign take    = tdec && nonzero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value   <= '0;
            ovf     <= 1'b0;
            rsp_vld <= 1'b0;
            rsp_nz  <= 1'b0;
        end else begin
            if (inc && !take) begin
                if (value == MAXV) ovf <= 1'b1;
                else               value <= value + 1'b1;
            end else if (!inc && take) begin
                value <= value - 1'b1;
            end
            rsp_vld <= tdec;
            rsp_nz  <= nonzero;
        end
    end

endmodule

// File: rtl/retsel_resp.sv
module retsel_resp #(
    parameter int NSRC = 4
) (
    input  logic [NSRC-1:0] vld,
    input  logic [NSRC-1:0] nz,
    output logic [1:0]      cnt,
    output logic            any_nz
);
    localparam int CW = $clog2(NSRC + 1);

    logic [CW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < NSRC; i++) ones = ones + CW'(vld[i]);
        cnt    = (ones >= CW'(2)) ? 2'd2 : ones[1:0];
        any_nz = |(vld & nz);
    end

endmodule

// File: rtl/retsel_sequencer.sv
module retsel_sequencer
    import retsel_pkg::*;
#(
    parameter int               STATE_W    = 4,
    parameter int               NUM_CTR    = 2,
    parameter int               CTR_W      = 16,
    parameter int               EXT_ACT    = 4,
    parameter logic [EXT_ACT-1:0] EXT_RESP = '1,
    parameter int               CYCLE_LEN  = 8,
    parameter int               INIT_STATE = 0,
    localparam int              ACT_W      = 1 + 2 * NUM_CTR + EXT_ACT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_en,
    input  logic                     prog_we,
    input  logic [STATE_W-1:0]       prog_state,
    input  logic [1:0]               prog_sel,
    input  logic [STATE_W-1:0]       prog_next,
    input  logic [ACT_W-1:0]         prog_mask,
    output logic [EXT_ACT-1:0]       act_strobe,
    input  logic                     ret_valid,
    input  logic                     ret_nz,
    output logic                     running,
    output logic                     halted,
    output logic                     error,
    output logic [STATE_W-1:0]       cur_state,
    output logic                     last_nz,
    output logic [NUM_CTR*CTR_W-1:0] ctr_value,
    output logic [NUM_CTR-1:0]       ctr_ovf
);
    localparam int INC_LSB = 1;
    localparam int DEC_LSB = 1 + NUM_CTR;
    localparam int EXT_LSB = 1 + 2 * NUM_CTR;
    localparam int NSRC    = 2 + NUM_CTR;
    localparam int TW      = (CYCLE_LEN > 2) ? $clog2(CYCLE_LEN) : 1;
    localparam logic [TW-1:0] WLAST = TW'(CYCLE_LEN - 1);
    localparam logic [ACT_W-1:0] RESP_BITS =
        {EXT_RESP, {NUM_CTR{1'b1}}, {NUM_CTR{1'b0}}, 1'b1};

    seq_state_t         st_q, st_d;
    logic [STATE_W-1:0] cur_q, cur_d;
    logic               last_q, last_d;
    logic [ACT_W-1:0]   act_q, act_d;
    logic [TW-1:0]      wcnt_q, wcnt_d;
    logic [1:0]         acc_q, acc_d;
    logic               accnz_q, accnz_d;
    logic               nop_q;

    logic               ent_vld;
    logic [STATE_W-1:0] ent_next;
    logic [ACT_W-1:0]   ent_mask;

    logic [NUM_CTR-1:0] ctr_rv, ctr_rnz;
    logic [NSRC-1:0]    src_vld, src_nz;
    logic [1:0]         cur_cnt, tot;
    logic               cur_nz, tot_nz;
    logic [2:0]         sum3;

    retsel_progmem #(.STATE_W(STATE_W), .ACT_W(ACT_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (prog_we && !run_en),
        .wstate   (prog_state),
        .wsel     (prog_sel),
        .wnext    (prog_next),
        .wmask    (prog_mask),
        .rstate   (cur_q),
        .rlast    (last_q),
        .ent_vld  (ent_vld),
        .ent_next (ent_next),
        .ent_mask (ent_mask)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        retsel_ctr #(.CTR_W(CTR_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (act_q[INC_LSB + i]),
            .tdec    (act_q[DEC_LSB + i]),
            .value   (ctr_value[i*CTR_W +: CTR_W]),
            .ovf     (ctr_ovf[i]),
            .rsp_vld (ctr_rv[i]),
            .rsp_nz  (ctr_rnz[i])
        );
    end

    assign src_vld = {ret_valid && (st_q == SQ_WAIT), ctr_rv, nop_q};
    assign src_nz  = {ret_nz, ctr_rnz, 1'b0};

    retsel_resp #(.NSRC(NSRC)) u_resp (
        .vld    (src_vld),
        .nz     (src_nz),
        .cnt    (cur_cnt),
        .any_nz (cur_nz)
    );

    assign sum3   = {1'b0, acc_q} + {1'b0, cur_cnt};
    assign tot    = (sum3 >= 3'd2) ? 2'd2 : sum3[1:0];
    assign tot_nz = accnz_q | cur_nz;

    // Next-state process
    always_comb begin
        st_d    = st_q;
        cur_d   = cur_q;
        last_d  = last_q;
        act_d   = '0;
        wcnt_d  = wcnt_q;
        acc_d   = acc_q;
        accnz_d = accnz_q;
        if (!run_en) begin
            st_d = SQ_IDLE;
        end else begin
            unique case (st_q)
                SQ_IDLE: begin
                    st_d   = SQ_FETCH;
                    cur_d  = STATE_W'(INIT_STATE);
                    last_d = 1'b0;
                end
                SQ_FETCH: begin
                    if (!ent_vld) begin
                        st_d = SQ_FAULT;
                    end else begin
                        act_d   = ent_mask;
                        wcnt_d  = '0;
                        acc_d   = 2'd0;
                        accnz_d = 1'b0;
                        st_d    = (|(ent_mask & RESP_BITS)) ? SQ_WAIT : SQ_HALT;
                    end
                end
                SQ_WAIT: begin
                    acc_d   = tot;
                    accnz_d = tot_nz;
                    if (wcnt_q == WLAST) begin
                        wcnt_d = '0;
                        if (tot == 2'd1) begin
                            st_d   = SQ_FETCH;
                            cur_d  = ent_next;
                            last_d = tot_nz;
                        end else if (tot != 2'd0) begin
                            st_d = SQ_FAULT;
                        end
                    end else begin
                        wcnt_d = wcnt_q + 1'b1;
                    end
                end
                SQ_HALT, SQ_FAULT: begin
                    st_d = st_q;
                end
                default: st_d = SQ_IDLE;
            endcase
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            cur_q   <= STATE_W'(INIT_STATE);
            last_q  <= 1'b0;
            act_q   <= '0;
            wcnt_q  <= '0;
            acc_q   <= 2'd0;
            accnz_q <= 1'b0;
            nop_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            cur_q   <= cur_d;
            last_q  <= last_d;
            act_q   <= act_d;
            wcnt_q  <= wcnt_d;
            acc_q   <= acc_d;
            accnz_q <= accnz_d;
            nop_q   <= act_q[0];
        end
    end

    // Output process
    always_comb begin
        running    = (st_q == SQ_FETCH) || (st_q == SQ_WAIT);
        halted     = (st_q == SQ_HALT);
        error      = (st_q == SQ_FAULT);
        act_strobe = act_q[EXT_LSB +: EXT_ACT];
        cur_state  = cur_q;
        last_nz    = last_q;
    end

endmodule

// File: rtl/retsel_checker.sv
module retsel_checker #(
    parameter int EXT_ACT = 4,
    parameter int NUM_CTR = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run_en,
    input logic               running,
    input logic               halted,
    input logic               error,
    input logic [EXT_ACT-1:0] act_strobe,
    input logic [NUM_CTR-1:0] ctr_ovf
);

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!running && !halted && !error)); // R1

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && run_en) |=> halted); // R5

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (error && run_en) |=> error); // R6

    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({running, halted, error})); // R6

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_strobe != '0) |=> (act_strobe == '0)); // R7

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ovf
        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ctr_ovf[i] |=> ctr_ovf[i]); // R10
    end

endmodule

bind retsel_sequencer retsel_checker #(
    .EXT_ACT (EXT_ACT),
    .NUM_CTR (NUM_CTR)
) u_retsel_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .running    (running),
    .halted     (halted),
    .error      (error),
    .act_strobe (act_strobe),
    .ctr_ovf    (ctr_ovf)
);

// File: tb/retsel_sequencer_bench.sv
module retsel_sequencer_bench;
    localparam int STATE_W = 5;
    localparam int NUM_CTR = 2;
    localparam int CTR_W   = 4;
    localparam int EXT_ACT = 2;
    localparam int CYC     = 4;
    localparam int ACT_W   = 1 + 2 * NUM_CTR + EXT_ACT;
    localparam int MAXV    = (1 << CTR_W) - 1;

    // Mask bits: 0 NOP, 1..2 inc, 3..4 tdec, 5..6 external
    localparam logic [ACT_W-1:0] M_NOP  = 7'b0000001;
    localparam logic [ACT_W-1:0] M_INC0 = 7'b0000010;
    localparam logic [ACT_W-1:0] M_INC1 = 7'b0000100;
    localparam logic [ACT_W-1:0] M_DEC0 = 7'b0001000;
    localparam logic [ACT_W-1:0] M_DEC1 = 7'b0010000;
    localparam logic [ACT_W-1:0] M_EXT0 = 7'b0100000;
    localparam logic [ACT_W-1:0] M_EXT1 = 7'b1000000;

    localparam logic [1:0] S_Z = 2'd0, S_NZ = 2'd1, S_BOTH = 2'd2, S_ZONLY = 2'd3;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     run_en = 1'b0;
    logic                     prog_we = 1'b0;
    logic [STATE_W-1:0]       prog_state = '0;
    logic [1:0]               prog_sel = '0;
    logic [STATE_W-1:0]       prog_next = '0;
    logic [ACT_W-1:0]         prog_mask = '0;
    logic [EXT_ACT-1:0]       act_strobe;
    logic                     ret_valid = 1'b0;
    logic                     ret_nz = 1'b0;
    logic                     running, halted, error, last_nz;
    logic [STATE_W-1:0]       cur_state;
    logic [NUM_CTR*CTR_W-1:0] ctr_value;
    logic [NUM_CTR-1:0]       ctr_ovf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    retsel_sequencer #(
        .STATE_W(STATE_W), .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .EXT_ACT(EXT_ACT),
        .EXT_RESP(2'b01), .CYCLE_LEN(CYC), .INIT_STATE(0)
    ) u_retsel_sequencer (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .prog_we(prog_we),
        .prog_state(prog_state), .prog_sel(prog_sel), .prog_next(prog_next),
        .prog_mask(prog_mask), .act_strobe(act_strobe), .ret_valid(ret_valid),
        .ret_nz(ret_nz), .running(running), .halted(halted), .error(error),
        .cur_state(cur_state), .last_nz(last_nz), .ctr_value(ctr_value),
        .ctr_ovf(ctr_ovf)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int sat_count(int n);
        return (n > MAXV) ? MAXV : n;
    endfunction

    function automatic int ctr(int i);
        return int'(ctr_value[i*CTR_W +: CTR_W]);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        run_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(int st, logic [1:0] sel, int nxt, logic [ACT_W-1:0] m);
        prog_we    = 1'b1;
        prog_state = STATE_W'(st);
        prog_sel   = sel;
        prog_next  = STATE_W'(nxt);
        prog_mask  = m;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic start_run();
        run_en = 1'b0;
        @(negedge clk);
        run_en = 1'b1;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (halted || error) return;
        end
    endtask

    task automatic check_end(string req, bit exp_halt, bit exp_err, int exp_st);
        chk(halted == exp_halt, req, "halted", int'(halted), int'(exp_halt));
        chk(error == exp_err, req, "error", int'(error), int'(exp_err));
        chk(int'(cur_state) == exp_st, req, "cur_state", int'(cur_state), exp_st);
    endtask

    initial begin
        void'($urandom(32'h5eed_0017));

        // R1 reset state
        do_reset();
        chk(!running && !halted && !error, "R1", "status after reset",
            int'({running, halted, error}), 0);
        chk(act_strobe == '0, "R1", "strobes after reset", int'(act_strobe), 0);
        chk(ctr_value == '0 && ctr_ovf == '0, "R1", "counters after reset",
            int'(ctr_value), 0);
        // R3 no entry valid after reset: first fetch faults
        start_run();
        wait_done();
        check_end("R3", 1'b0, 1'b1, 0);
        run_en = 1'b0;
        @(negedge clk);
        chk(!running && !halted && !error, "R1", "idle after run_en low",
            int'({running, halted, error}), 0);

        // Random chain loads plus transfer: R2 R5 R8 R9
        for (int it = 0; it < 3; it++) begin
            int n;
            n = 1 + int'($urandom_range(9));
            do_reset();
            for (int s = 0; s < n; s++) wr(s, S_BOTH, s + 1, M_NOP | M_INC0);
            wr(n, S_BOTH, n + 1, M_DEC1);
            wr(n + 1, S_BOTH, n + 1, '0);
            start_run();
            wait_done();
            check_end("R5", 1'b1, 1'b0, n + 1);
            chk(ctr(0) == sat_count(n), "R8", "chain count", ctr(0), sat_count(n));
            chk(ctr(1) == 0 && last_nz == 1'b0, "R9", "tdec at zero answers Z",
                ctr(1), 0);
            chk(ctr_ovf == '0, "R10", "no overflow below max", int'(ctr_ovf), 0);
            // transfer counter 0 into counter 1
            run_en = 1'b0;
            @(negedge clk);
            wr(0, S_Z, 1, M_DEC0);
            wr(1, S_NZ, 1, M_DEC0 | M_INC1);
            wr(1, S_Z, 1, '0);
            start_run();
            wait_done();
            check_end("R2", 1'b1, 1'b0, 1);
            chk(ctr(0) == 0 && ctr(1) == n, "R9", "transfer result", ctr(1), n);
        end

        // R3 Z-only leaves NZ invalid
        do_reset();
        wr(0, S_ZONLY, 1, M_NOP | M_INC0);
        wr(1, S_ZONLY, 1, M_DEC0);
        start_run();
        wait_done();
        check_end("R3", 1'b0, 1'b1, 1);
        chk(ctr(0) == 0, "R9", "tdec at one", ctr(0), 0);

        // R6 two internal answers in one period
        do_reset();
        wr(0, S_Z, 1, M_NOP | M_DEC0);
        start_run();
        wait_done();
        check_end("R6", 1'b0, 1'b1, 0);

        // R6 NOP and external answer in one period
        do_reset();
        wr(0, S_Z, 1, M_NOP | M_EXT0);
        wr(1, S_BOTH, 1, '0);
        start_run();
        for (int k = 0; k < 20 && act_strobe[0] !== 1'b1; k++) @(negedge clk);
        ret_valid = 1'b1;
        ret_nz = 1'b1;
        @(negedge clk);
        ret_valid = 1'b0;
        wait_done();
        check_end("R6", 1'b0, 1'b1, 0);

        // Late external answers with writes during the wait: R4 R7 R12
        for (int it = 0; it < 4; it++) begin
            int d;
            int pulses;
            bit nz;
            bit still;
            d = 2 + int'($urandom_range(3 * CYC));
            nz = 1'($urandom_range(1));
            do_reset();
            wr(0, S_BOTH, 1, M_EXT0);
            wr(1, S_Z, 1, '0);
            wr(1, S_NZ, 2, M_NOP | M_INC0);
            wr(2, S_BOTH, 2, '0);
            start_run();
            pulses = 0;
            for (int k = 0; k < 20 && act_strobe[0] !== 1'b1; k++) @(negedge clk);
            pulses = 1;
            still = 1'b1;
            for (int k = 0; k < d; k++) begin
                prog_we = 1'b1;
                prog_state = 5'd1;
                prog_sel = S_BOTH;
                prog_next = 5'd7;
                prog_mask = M_INC1;
                @(negedge clk);
                if (act_strobe[0]) pulses++;
                if (!running || cur_state != 0) still = 1'b0;
            end
            prog_we = 1'b0;
            chk(pulses == 1, "R7", "strobe pulses while waiting", pulses, 1);
            chk(still, "R7", "still running in state 0", int'(still), 1);
            ret_valid = 1'b1;
            ret_nz = nz;
            @(negedge clk);
            ret_valid = 1'b0;
            wait_done();
            check_end("R12", 1'b1, 1'b0, nz ? 2 : 1);
            chk(ctr(0) == (nz ? 1 : 0) && ctr(1) == 0, "R4",
                "writes ignored while running", ctr(0), nz ? 1 : 0);
        end

        // R5 entry with only a non-answering external action
        do_reset();
        wr(0, S_Z, 3, M_EXT1 | M_INC1);
        start_run();
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (act_strobe[1]) seen++;
            end
            chk(seen == 1, "R5", "actions still issued at halt", seen, 1);
        end
        check_end("R5", 1'b1, 1'b0, 0);
        chk(ctr(1) == 1, "R5", "increment at halt", ctr(1), 1);

        // R10 saturation
        do_reset();
        for (int s = 0; s < 20; s++) wr(s, S_BOTH, s + 1, M_NOP | M_INC0);
        wr(20, S_BOTH, 20, '0);
        start_run();
        wait_done();
        check_end("R10", 1'b1, 1'b0, 20);
        chk(ctr(0) == sat_count(20), "R10", "saturated value", ctr(0), sat_count(20));
        chk(ctr_ovf == 2'b01, "R10", "sticky overflow", int'(ctr_ovf), 1);

        // R11 increment and test-and-decrement together
        do_reset();
        wr(0, S_Z, 1, M_INC0 | M_DEC0);
        wr(1, S_Z, 2, M_INC0 | M_DEC0);
        wr(2, S_BOTH, 2, '0);
        start_run();
        wait_done();
        check_end("R11", 1'b1, 1'b0, 2);
        chk(ctr(0) == 1, "R11", "net value", ctr(0), 1);
        chk(last_nz == 1'b1, "R11", "second test saw old value 1", int'(last_nz), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule